// File: doc/BRIEF.md
# Fixed-Point Fraction Multiplier with Selectable Result Modes

The block multiplies two 16-bit fixed-point fractions and turns the product into a register-half result in one of four modes. Three modes treat the operands as signed 1.15 values. Their product gets a one-bit left shift to become a 1.31 value. Those three modes then either round, truncate, or double and round the shifted product before clamping it into 1.15. The fourth mode treats both operands as unsigned 0.16 values and keeps the upper half of the product. A control bit chooses between round-half-to-even and round-half-up wherever rounding takes place.

A valid strobe captures the operands, the mode and the rounding style. One clock later the outputs show the 16-bit result, a saturation flag and an output-valid strobe. The default signed mode also delivers the full 32-bit corrected product, clamped to 1.31 and marked by its own valid bit, with an overflow flag for the one operand pair that cannot be represented. The block is meant for a datapath that needs a single fraction multiply per strobe with a chosen narrowing policy.

Top module: `frac_mul`

## Requirements
- R1: One clock edge after `vld_i` is sampled high, `vld_o` is high and the outputs show the result for the operands captured at that edge. On a cycle after an edge where `vld_i` was low, `vld_o` is low and `res16_o` and `res32_o` keep their values.
- R2: Mode encoding on `mode_i` is 2'b00 signed default, 2'b01 signed truncate, 2'b10 unsigned truncate and 2'b11 signed scale-and-round. In the default mode the product of the signed 1.15 operands is shifted left by one, rounded at bit 16 and clamped into 16'h8000..16'h7FFF.
- R3: Signed truncate drops the bits below bit 16 of the shifted product without rounding, so the result moves toward minus infinity. It then clamps the result into 16'h8000..16'h7FFF.
- R4: Unsigned truncate multiplies the operands as unsigned fractions and returns the upper 16 bits of the 32-bit product. It never raises `sat_o`.
- R5: Scale-and-round shifts the product left by two in total, rounds at bit 16 and clamps into 16'h8000..16'h7FFF.
- R6: `rnd_i`=1 rounds an exact half upward (add half an LSB, then drop the fraction). `rnd_i`=0 rounds an exact half to the even result. All other fractions round to the nearest value either way.
- R7: In the default mode `res32_vld_o` is high with a valid result, and `res32_o` holds the left-shifted product clamped to 32'h7FFFFFFF. In every other mode `res32_vld_o` is low and `res32_o` is zero.
- R8: `sat_o` is high exactly when `vld_o` is high and the 16-bit result was clamped. A clamped signed result equals 16'h7FFF or 16'h8000.
- R9: `ovf_o` is high exactly when a default-mode 32-bit result was clamped. This happens only for 16'h8000 times 16'h8000, which gives 32'h7FFFFFFF on the wide output and 16'h7FFF on the half output.
- R10: While reset is active and after it, until the first strobe, `vld_o`, `sat_o`, `ovf_o` and `res32_vld_o` are low and `res16_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operand strobe |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| mode_i | input | 2 | Result mode select |
| rnd_i | input | 1 | Rounding style: 1 half-up, 0 half-to-even |
| vld_o | output | 1 | Result valid |
| res16_o | output | 16 | Register-half result |
| res32_o | output | 32 | Wide result in default mode, else zero |
| res32_vld_o | output | 1 | Wide result valid |
| sat_o | output | 1 | Half result was clamped |
| ovf_o | output | 1 | Wide result was clamped |

## Verification
The bench applies the same operand pairs in several modes so that mode behaviours can be told apart. Small positive values with a nonzero fraction separate truncation from rounding. Negative products show that truncation moves toward minus infinity. Minus one times minus one gives a clamp in the signed modes but a plain 0x4000 in the unsigned mode. Products whose dropped fraction is exactly one half, with both even and odd kept parts, separate the two rounding styles. Doubled products beyond plus or minus one exercise both clamp bounds of the scale mode. Strobe-free cycles and back-to-back strobes fix the one-cycle latency and the holding behaviour.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
   typedef enum logic [1:0] {
      MD_DEF    = 2'b00,
      MD_STRUNC = 2'b01,
      MD_UTRUNC = 2'b10,
      MD_SCALE  = 2'b11
   } fmul_mode_e;
endpackage

// File: rtl/fmul_product.sv
// Sign-aware full product: operands are extended by one bit, with zero or
// sign fill chosen per call, so one signed multiplier serves both kinds.
module fmul_product #(
   parameter int DW = 16,
   localparam int W = 2*DW + 2
) (
   input  logic [DW-1:0]       a_i,
   input  logic [DW-1:0]       b_i,
   input  logic                uns_i,
   output logic signed [W-1:0] p_o
);
   logic signed [DW:0] ae, be;

   always_comb begin
      ae  = uns_i ? {1'b0, a_i} : {a_i[DW-1], a_i};
      be  = uns_i ? {1'b0, b_i} : {b_i[DW-1], b_i};
      p_o = ae * be;
   end
endmodule

// File: rtl/fmul_round.sv
// Rounds away the lowest FRAC bits; exact halves go up or to even.
module fmul_round #(
   parameter int IN_W = 34,
   parameter int FRAC = 16,
   localparam int EW = IN_W + 1
) (
   input  logic signed [IN_W-1:0] x_i,
   input  logic                   biased_i,
   output logic signed [EW-1:0]   q_o
);
   localparam logic signed [EW-1:0] ONE  = 1;
   localparam logic signed [EW-1:0] HALF = ONE <<< (FRAC-1);

   logic signed [EW-1:0] xe, sum, qr;
   logic                 tie;

   always_comb begin
      xe  = {x_i[IN_W-1], x_i};
      sum = xe + HALF;
      qr  = sum >>> FRAC;
      tie = (xe[FRAC-1:0] == HALF[FRAC-1:0]);
      q_o = (tie && !biased_i) ? {qr[EW-1:1], 1'b0} : qr;
   end
endmodule

// File: rtl/fmul_clamp.sv
// Clamps a wide value into OUT_W bits, signed or unsigned range per variant.
module fmul_clamp #(
   parameter int IN_W   = 35,
   parameter int OUT_W  = 16,
   parameter bit SIGNED = 1'b1
) (
   input  logic signed [IN_W-1:0] x_i,
   output logic [OUT_W-1:0]       y_o,
   output logic                   sat_o
);
   localparam logic signed [IN_W-1:0] ONE = 1;

   logic signed [IN_W-1:0] hi, lo;
   logic                   over, under;

   generate
      if (IN_W <= OUT_W + 1) begin : g_bad_width
         $error("fmul_clamp: IN_W must exceed OUT_W + 1");
      end
      if (SIGNED) begin : g_signed
         assign hi = (ONE <<< (OUT_W-1)) - ONE;
         assign lo = -(ONE <<< (OUT_W-1));
      end else begin : g_unsigned
         assign hi = (ONE <<< OUT_W) - ONE;
         assign lo = '0;
      end
   endgenerate

   always_comb begin
      over  = (x_i > hi);
      under = (x_i < lo);
      sat_o = over | under;
      if (over)       y_o = hi[OUT_W-1:0];
      else if (under) y_o = lo[OUT_W-1:0];
      else            y_o = x_i[OUT_W-1:0];
   end
endmodule

// File: rtl/frac_mul.sv
module frac_mul #(
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vld_i,
   input  logic [DW-1:0]   a_i,
   input  logic [DW-1:0]   b_i,
   input  logic [1:0]      mode_i,
   input  logic            rnd_i,
   output logic            vld_o,
   output logic [DW-1:0]   res16_o,
   output logic [2*DW-1:0] res32_o,
   output logic            res32_vld_o,
   output logic            sat_o,
   output logic            ovf_o
);
   import fmul_pkg::*;

   localparam int PW = 2*DW;
   localparam int W  = PW + 2;
   localparam int QW = W + 1;
   localparam int NR = 2;
   localparam int NM = 4;

   generate
      if (DW < 4) begin : g_bad_dw
         $error("frac_mul: DW must be at least 4");
      end
   endgenerate

   // operand capture
   logic             vld_q, rnd_q;
   logic [DW-1:0]    a_q, b_q;
   fmul_mode_e       mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         mode_q <= MD_DEF;
         rnd_q  <= 1'b0;
      end else begin
         vld_q <= vld_i;
         if (vld_i) begin
            a_q    <= a_i;
            b_q    <= b_i;
            mode_q <= fmul_mode_e'(mode_i);
            rnd_q  <= rnd_i;
         end
      end
   end

   // product and fractional corrections
   logic signed [W-1:0] prod, corr, dbl;
   logic [NR-1:0][W-1:0]  rin;
   logic [NR-1:0][QW-1:0] rq;
   logic [QW-1:0]         tq, uq;
   logic [NM-1:0][QW-1:0] cin;
   logic [NM-1:0][DW-1:0] hv;
   logic [NM-1:0]         hs;
   logic [PW-1:0]         w32;
   logic                  wsat, wide_on;

   fmul_product #(.DW(DW)) i_prod (
      .a_i   (a_q),
      .b_i   (b_q),
      .uns_i (mode_q == MD_UTRUNC),
      .p_o   (prod)
   );

   always_comb begin
      corr   = prod <<< 1;
      dbl    = prod <<< 2;
      rin[0] = corr;
      rin[1] = dbl;
      tq     = {corr[W-1], corr >>> DW};
      uq     = {prod[W-1], prod >>> DW};
   end

   for (genvar g = 0; g < NR; g++) begin : g_rnd
      fmul_round #(.IN_W(W), .FRAC(DW)) i_rnd (
         .x_i      (rin[g]),
         .biased_i (rnd_q),
         .q_o      (rq[g])
      );
   end

   // clamp slot order follows the mode encoding
   assign cin = {rq[1], uq, tq, rq[0]};

   for (genvar g = 0; g < NM; g++) begin : g_clamp
      fmul_clamp #(.IN_W(QW), .OUT_W(DW), .SIGNED(g != 2)) i_clamp (
         .x_i   (cin[g]),
         .y_o   (hv[g]),
         .sat_o (hs[g])
      );
   end

   fmul_clamp #(.IN_W(W), .OUT_W(PW), .SIGNED(1'b1)) i_wide (
      .x_i   (corr),
      .y_o   (w32),
      .sat_o (wsat)
   );

   always_comb begin
      wide_on     = (mode_q == MD_DEF);
      vld_o       = vld_q;
      res16_o     = hv[mode_q];
      sat_o       = vld_q & hs[mode_q];
      res32_o     = wide_on ? w32 : '0;
      res32_vld_o = vld_q & wide_on;
      ovf_o       = vld_q & wide_on & wsat;
   end
endmodule

// File: rtl/frac_mul_chk.sv
module frac_mul_chk #(
   parameter int DW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            vld_i,
   input logic [1:0]      mode_i,
   input logic            vld_o,
   input logic [DW-1:0]   res16_o,
   input logic [2*DW-1:0] res32_o,
   input logic            res32_vld_o,
   input logic            sat_o,
   input logic            ovf_o
);
   import fmul_pkg::*;

   localparam logic [DW-1:0]   SMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0]   SMIN = {1'b1, {(DW-1){1'b0}}};
   localparam logic [2*DW-1:0] WMAX = {1'b0, {(2*DW-1){1'b1}}};

   p_vld_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> vld_o);

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> (!vld_o && $stable(res16_o) && $stable(res32_o)));

   p_wide_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && mode_i != MD_DEF) |=> (!res32_vld_o && res32_o == '0));

   p_uns_nosat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && mode_i == MD_UTRUNC) |=> !sat_o);

   p_sat_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sat_o |-> (vld_o && (res16_o == SMAX || res16_o == SMIN)));

   p_ovf_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (res32_vld_o && res32_o == WMAX && res16_o == SMAX));

   p_flag_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (res32_vld_o || ovf_o) |-> vld_o);
endmodule

bind frac_mul frac_mul_chk #(.DW(DW)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .vld_i       (vld_i),
   .mode_i      (mode_i),
   .vld_o       (vld_o),
   .res16_o     (res16_o),
   .res32_o     (res32_o),
   .res32_vld_o (res32_vld_o),
   .sat_o       (sat_o),
   .ovf_o       (ovf_o)
);

// File: tb/test_frac_mul.sv
module test_frac_mul;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_i = 1'b0;
   logic [15:0] a_i = '0;
   logic [15:0] b_i = '0;
   logic [1:0]  mode_i = '0;
   logic        rnd_i = 1'b0;
   logic        vld_o, res32_vld_o, sat_o, ovf_o;
   logic [15:0] res16_o;
   logic [31:0] res32_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_mul #(.DW(16)) i_frac_mul (
      .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .a_i(a_i), .b_i(b_i),
      .mode_i(mode_i), .rnd_i(rnd_i), .vld_o(vld_o), .res16_o(res16_o),
      .res32_o(res32_o), .res32_vld_o(res32_vld_o), .sat_o(sat_o), .ovf_o(ovf_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // strobe one operand set at a falling edge, return after the next one
   task automatic apply(input logic [15:0] a, input logic [15:0] b,
                        input logic [1:0] m, input logic r);
      @(negedge clk);
      a_i = a; b_i = b; mode_i = m; rnd_i = r; vld_i = 1'b1;
      @(negedge clk);
      vld_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R10 vld", {31'b0, vld_o}, 32'd0);
      chk("R10 res16", {16'b0, res16_o}, 32'd0);
      chk("R10 flags", {29'b0, sat_o, ovf_o, res32_vld_o}, 32'd0);
   endtask

   task automatic t_default;
      apply(16'h4000, 16'h4000, 2'b00, 1'b1);
      chk("R2 half 0.5*0.5", {16'b0, res16_o}, 32'h2000);
      chk("R7 wide 0.5*0.5", res32_o, 32'h2000_0000);
      chk("R7 wide valid", {31'b0, res32_vld_o}, 32'd1);
      chk("R8 no sat", {31'b0, sat_o}, 32'd0);
      apply(16'h0001, 16'h7FFF, 2'b00, 1'b0);
      chk("R2 rounds up", {16'b0, res16_o}, 32'h0001);
      chk("R7 wide small", res32_o, 32'h0000_FFFE);
      apply(16'hC000, 16'h4000, 2'b00, 1'b0);
      chk("R2 negative", {16'b0, res16_o}, 32'hE000);
      chk("R7 wide negative", res32_o, 32'hE000_0000);
   endtask

   task automatic t_minus_one;
      apply(16'h8000, 16'h8000, 2'b00, 1'b1);
      chk("R9 half clamp", {16'b0, res16_o}, 32'h7FFF);
      chk("R9 wide clamp", res32_o, 32'h7FFF_FFFF);
      chk("R9 ovf", {31'b0, ovf_o}, 32'd1);
      chk("R8 sat", {31'b0, sat_o}, 32'd1);
   endtask

   task automatic t_strunc;
      apply(16'h0001, 16'h7FFF, 2'b01, 1'b1);
      chk("R3 drops fraction", {16'b0, res16_o}, 32'h0000);
      chk("R7 no wide", {31'b0, res32_vld_o}, 32'd0);
      chk("R7 wide zero", res32_o, 32'd0);
      apply(16'hFFFF, 16'h7FFF, 2'b01, 1'b1);
      chk("R3 toward -inf", {16'b0, res16_o}, 32'hFFFF);
      apply(16'h8000, 16'h8000, 2'b01, 1'b0);
      chk("R3 clamp", {16'b0, res16_o}, 32'h7FFF);
      chk("R8 sat trunc", {31'b0, sat_o}, 32'd1);
      chk("R9 no ovf", {31'b0, ovf_o}, 32'd0);
   endtask

   task automatic t_utrunc;
      apply(16'hFFFF, 16'hFFFF, 2'b10, 1'b0);
      chk("R4 max", {16'b0, res16_o}, 32'hFFFE);
      chk("R4 no sat", {31'b0, sat_o}, 32'd0);
      apply(16'h8000, 16'h8000, 2'b10, 1'b1);
      chk("R4 half*half", {16'b0, res16_o}, 32'h4000);
   endtask

   task automatic t_scale;
      apply(16'h4000, 16'h4000, 2'b11, 1'b1);
      chk("R5 doubled", {16'b0, res16_o}, 32'h4000);
      chk("R5 no sat", {31'b0, sat_o}, 32'd0);
      apply(16'h6000, 16'h6000, 2'b11, 1'b1);
      chk("R5 clamp high", {16'b0, res16_o}, 32'h7FFF);
      chk("R8 sat high", {31'b0, sat_o}, 32'd1);
      apply(16'h6000, 16'hA000, 2'b11, 1'b0);
      chk("R5 clamp low", {16'b0, res16_o}, 32'h8000);
      chk("R8 sat low", {31'b0, sat_o}, 32'd1);
   endtask

   task automatic t_round;
      apply(16'h0001, 16'h4000, 2'b00, 1'b0);
      chk("R6 even tie down", {16'b0, res16_o}, 32'h0000);
      apply(16'h0001, 16'h4000, 2'b00, 1'b1);
      chk("R6 biased tie up", {16'b0, res16_o}, 32'h0001);
      apply(16'h0003, 16'h4000, 2'b00, 1'b0);
      chk("R6 even tie odd", {16'b0, res16_o}, 32'h0002);
      apply(16'h0003, 16'h4000, 2'b00, 1'b1);
      chk("R6 biased tie odd", {16'b0, res16_o}, 32'h0002);
      apply(16'h0001, 16'h6000, 2'b00, 1'b0);
      chk("R6 above half", {16'b0, res16_o}, 32'h0001);
      apply(16'h0001, 16'h2000, 2'b11, 1'b0);
      chk("R6 scale even tie", {16'b0, res16_o}, 32'h0000);
      apply(16'h0001, 16'h2000, 2'b11, 1'b1);
      chk("R6 scale biased tie", {16'b0, res16_o}, 32'h0001);
   endtask

   task automatic t_hold;
      apply(16'h4000, 16'h4000, 2'b00, 1'b0);
      a_i = 16'h7FFF; b_i = 16'h7FFF; mode_i = 2'b11;
      @(negedge clk);
      chk("R1 vld low", {31'b0, vld_o}, 32'd0);
      chk("R1 hold res16", {16'b0, res16_o}, 32'h2000);
      chk("R1 hold res32", res32_o, 32'h2000_0000);
      chk("R8 no sat idle", {31'b0, sat_o}, 32'd0);
      // back-to-back strobes
      @(negedge clk);
      a_i = 16'h2000; b_i = 16'h4000; mode_i = 2'b00; rnd_i = 1'b1; vld_i = 1'b1;
      @(negedge clk);
      chk("R1 first of pair", {16'b0, res16_o}, 32'h1000);
      chk("R1 vld pair", {31'b0, vld_o}, 32'd1);
      a_i = 16'hFFFF; b_i = 16'hFFFF; mode_i = 2'b10;
      @(negedge clk);
      vld_i = 1'b0;
      chk("R1 second of pair", {16'b0, res16_o}, 32'hFFFE);
      chk("R7 wide off", {31'b0, res32_vld_o}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default();
      t_minus_one();
      t_strunc();
      t_utrunc();
      t_scale();
      t_round();
      t_hold();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule